// File: doc/BRIEF.md
# Byte-Framed Serial Register Port

This block is the serial slave port of a data-converter control core. A host reaches a small register file through four wires: a serial clock, a data input, a data output and an active-low select. Every transaction opens with one command byte. That byte chooses read or write and names a 6-bit register address. A data phase of 8, 16 or 24 bits follows. Its length is fixed by the register that was addressed, and for the conversion-result registers it also depends on a width bit in the mode register.

All serial inputs are brought into the core clock domain through synchronizers. Serial clock edges are then found by edge detection, so the whole block runs on one system clock. That clock must be several times faster than the serial clock. The register file holds calibration words, an I/O port byte, a mode byte and plain storage for test and checksum words. It also returns the conversion results and the ready flags, which the conversion core supplies on parallel inputs. The port keeps its byte framing by counting serial clock edges alone. It can therefore run with the select tied low, as a 3-wire link.

Top module: `sreg_port`

## Requirements
- R1: DIN is sampled on the rising serial clock edge, MSB first. In the command byte, bit 6 selects read (1) or write (0) and bits 5:0 give the address. Bit 7 is sent as 0.
- R2: The data phase is 24 bits for addresses 03h, 06h, 07h, 10h, 12h, 18h and 1Ah. It is 16 bits for 05h. Every other address, including 00h, undefined addresses and the mode addresses, takes 8 bits.
- R3: DOUT changes only on falling serial clock edges and sends the read value MSB first. The first bit appears on the falling edge that follows the last command bit. DOUT is 0 during command bytes and during write transactions.
- R4: Active-low reset restores the power-on values. The I/O port reads 30h. The revision byte reads 24h, whose low nibble is 4h. 06h, 07h, 10h and 12h read 800000h. 18h and 1Ah read 200000h. Test, checksum and mode read 0, and the mode channel is 0.
- R5: Address 08h returns channel 0 result data and 0Ah returns channel 1. When mode bit 1 is 0, the read is 16 bits and carries the upper 16 bits of the result. When mode bit 1 is 1, the read is 24 bits.
- R6: The mode register is one byte that answers at 38h and 3Ah. A write through 38h sets the mode channel output to 0. A write through 3Ah sets it to 1. Reads at 38h return the mode byte, and reads at 3Ah return zeros.
- R7: A read of 00h, which is write-only, or of any undefined address returns 8 zero bits.
- R8: A write to a read-only address (02h, 04h, 08h, 0Ah) uses that register's data length and changes no stored value. The next transaction is framed normally.
- R9: Raising chip select in the middle of a transaction discards it. No write takes effect, and the next low phase starts with a command byte.
- R10: With chip select held low, transactions can follow back to back. Framing is kept by counting edges.
- R11: Asserting reset in the middle of a transaction returns both the framing and every register to the power-on state.
- R12: Address 04h returns {6'b0, ready flags}, with the channel 1 flag in bit 1 and the channel 0 flag in bit 0.
- R13: Writes to the I/O port store bits 7:3 and bit 0. Bits 2:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts the current frame |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out |
| ch0_data | input | 24 | Channel 0 conversion result |
| ch1_data | input | 24 | Channel 1 conversion result |
| adc_rdy | input | 2 | Per-channel data-ready flags |
| mode_q | output | 8 | Current mode byte |
| mode_ch | output | 1 | Channel targeted by the last mode write |
| io_q | output | 8 | I/O port register |
| adc_zs_q | output | 24 | Converter zero-scale calibration word |
| adc_fs_q | output | 24 | Converter full-scale calibration word |

## Verification
The hardest condition to reach from the ports is a frame that stops at an arbitrary bit: part way through a data phase, or at a reset that arrives between serial edges. In that case the framing counter must drop its state and leave the registers untouched. The bench reaches it by sending a 10-bit slice of a 24-bit write and then raising select. It also pulls reset in the middle of a data phase. A later read then shows whether the framing and the stored values recovered. Back-to-back transactions with select held low check that edge counting alone keeps byte alignment. Those transactions include a data-length switch caused by the mode width bit.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int DW  = 24;
  localparam int AW  = 6;
  localparam int CW  = 5;
  localparam int NCH = 2;
  localparam int MODE_WIDE_BIT = 1;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  localparam logic [AW-1:0] A_COMM     = 6'h00;
  localparam logic [AW-1:0] A_IO       = 6'h01;
  localparam logic [AW-1:0] A_REV      = 6'h02;
  localparam logic [AW-1:0] A_TEST     = 6'h03;
  localparam logic [AW-1:0] A_STAT     = 6'h04;
  localparam logic [AW-1:0] A_CSUM     = 6'h05;
  localparam logic [AW-1:0] A_ADC_ZS   = 6'h06;
  localparam logic [AW-1:0] A_ADC_FS   = 6'h07;
  localparam logic [AW-1:0] A_RESULT   = 6'h08;
  localparam logic [AW-1:0] A_CH_ZS    = 6'h10;
  localparam logic [AW-1:0] A_CH_FS    = 6'h18;
  localparam logic [AW-1:0] A_MODE     = 6'h38;
  localparam logic [AW-1:0] A_MODE_ALT = 6'h3A;

  localparam logic [7:0]    IO_RST    = 8'h30;
  localparam logic [7:0]    IO_WMASK  = 8'hF9;
  localparam logic [DW-1:0] MID_SCALE = 24'h800000;
  localparam logic [DW-1:0] CH_FS_RST = 24'h200000;

  localparam logic [CW-1:0] LEN_BYTE = 5'd8;
  localparam logic [CW-1:0] LEN_HALF = 5'd16;
  localparam logic [CW-1:0] LEN_FULL = 5'd24;

  // address of the per-channel copy: bit 1 carries the channel
  function automatic logic [AW-1:0] chan_addr(logic [AW-1:0] base, logic ch);
    return base | {{(AW-2){1'b0}}, ch, 1'b0};
  endfunction

  function automatic logic [CW-1:0] reg_len(logic [AW-1:0] a, logic wide);
    logic [CW-1:0] n;
    n = LEN_BYTE;
    if (a == A_TEST || a == A_ADC_ZS || a == A_ADC_FS) n = LEN_FULL;
    if (a == A_CSUM) n = LEN_HALF;
    for (int c = 0; c < NCH; c++) begin
      if (a == chan_addr(A_CH_ZS, c[0]) || a == chan_addr(A_CH_FS, c[0])) n = LEN_FULL;
      if (a == chan_addr(A_RESULT, c[0])) n = wide ? LEN_FULL : LEN_HALF;
    end
    return n;
  endfunction

  function automatic logic reg_writable(logic [AW-1:0] a);
    logic w;
    w = (a == A_IO) || (a == A_TEST) || (a == A_CSUM) || (a == A_ADC_ZS) ||
        (a == A_ADC_FS) || (a == A_MODE) || (a == A_MODE_ALT);
    for (int c = 0; c < NCH; c++)
      if (a == chan_addr(A_CH_ZS, c[0]) || a == chan_addr(A_CH_FS, c[0])) w = 1'b1;
    return w;
  endfunction

  // place a right-aligned value of len bits at the top of the shift word
  function automatic logic [DW-1:0] msb_align(logic [DW-1:0] v, logic [CW-1:0] len);
    case (len)
      LEN_BYTE: return {v[7:0], 16'h0000};
      LEN_HALF: return {v[15:0], 8'h00};
      default:  return v;
    endcase
  endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sreg_serial_if.sv
module sreg_serial_if
  import sreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_sync_n,
  input  logic          sclk_sync,
  input  logic          din_sync,
  input  logic          mode_wide,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          dout
);
  phase_e        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_q;
  logic [DW-1:0] in_sh, out_sh, in_next;
  logic          cmd_rd, load_pend, sclk_prev;
  logic [AW-1:0] cmd_addr;
  logic          rise_evt, fall_evt, last_bit;

  assign rise_evt = sclk_sync & ~sclk_prev & ~cs_sync_n;
  assign fall_evt = ~sclk_sync & sclk_prev & ~cs_sync_n;
  assign in_next  = {in_sh[DW-2:0], din_sync};
  assign last_bit = (cnt == len_q - 5'd1);
  assign rd_addr  = cmd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD; cnt <= '0; len_q <= LEN_BYTE;
      in_sh <= '0; out_sh <= '0; cmd_rd <= 1'b0; cmd_addr <= '0;
      load_pend <= 1'b0; sclk_prev <= 1'b0; dout <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      sclk_prev <= sclk_sync;
      wr_en     <= 1'b0;
      load_pend <= 1'b0;
      if (cs_sync_n) begin
        phase <= PH_CMD;
        cnt   <= '0;
        dout  <= 1'b0;
      end else begin
        if (rise_evt) begin
          in_sh <= in_next;
          if (phase == PH_CMD) begin
            if (cnt == LEN_BYTE - 5'd1) begin
              cmd_rd    <= in_next[6];
              cmd_addr  <= in_next[AW-1:0];
              len_q     <= reg_len(in_next[AW-1:0], mode_wide);
              load_pend <= in_next[6];
              phase     <= PH_DATA;
              cnt       <= '0;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end else if (last_bit) begin
            phase <= PH_CMD;
            cnt   <= '0;
            if (!cmd_rd) begin
              wr_en   <= 1'b1;
              wr_addr <= cmd_addr;
              wr_data <= in_next;
            end
          end else begin
            cnt <= cnt + 5'd1;
          end
        end
        if (load_pend) out_sh <= msb_align(rd_data, len_q);
        if (fall_evt) begin
          if (phase == PH_DATA && cmd_rd) begin
            dout   <= out_sh[DW-1];
            out_sh <= {out_sh[DW-2:0], 1'b0};
          end else begin
            dout <= 1'b0;
          end
        end
      end
    end
  end

  // R9: a high select drops the frame back to the command byte
  a_r9_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync_n |=> (phase == PH_CMD && cnt == '0));
  // R2: the data-phase bit counter never reaches the register length
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (cnt < len_q));
  // R1: a write is launched only by a sampling edge
  a_r1_wr_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rise_evt));
  // R10: one write pulse per frame
  a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R3: quiet output across command bytes
  a_r3_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && phase == PH_CMD) |=> !dout);
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter logic [3:0] REV_HI = 4'h2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [DW-1:0]  ch0_data,
  input  logic [DW-1:0]  ch1_data,
  input  logic [NCH-1:0] adc_rdy,
  output logic [7:0]     mode_q,
  output logic           mode_ch,
  output logic [7:0]     io_q,
  output logic [DW-1:0]  adc_zs_q,
  output logic [DW-1:0]  adc_fs_q
);
  localparam logic [7:0] REV_BYTE = {REV_HI, 4'h4};

  logic [DW-1:0] test_q;
  logic [15:0]   csum_q;
  logic [NCH-1:0][DW-1:0] zs_vec, fs_vec, res_vec;
  logic          wide;

  assign wide = mode_q[MODE_WIDE_BIT];
  assign res_vec[0] = ch0_data;
  assign res_vec[1] = ch1_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 8'h00; mode_ch <= 1'b0; io_q <= IO_RST;
      adc_zs_q <= MID_SCALE; adc_fs_q <= MID_SCALE;
      test_q <= '0; csum_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_IO:       io_q     <= wr_data[7:0] & IO_WMASK;
        A_TEST:     test_q   <= wr_data;
        A_CSUM:     csum_q   <= wr_data[15:0];
        A_ADC_ZS:   adc_zs_q <= wr_data;
        A_ADC_FS:   adc_fs_q <= wr_data;
        A_MODE:     begin mode_q <= wr_data[7:0]; mode_ch <= 1'b0; end
        A_MODE_ALT: begin mode_q <= wr_data[7:0]; mode_ch <= 1'b1; end
        default: ;
      endcase
    end
  end

  for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
    logic [DW-1:0] zs_q, fs_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        zs_q <= MID_SCALE;
        fs_q <= CH_FS_RST;
      end else if (wr_en) begin
        if (wr_addr == chan_addr(A_CH_ZS, gc[0])) zs_q <= wr_data;
        if (wr_addr == chan_addr(A_CH_FS, gc[0])) fs_q <= wr_data;
      end
    end
    assign zs_vec[gc] = zs_q;
    assign fs_vec[gc] = fs_q;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_IO:     rd_data = {16'h0, io_q};
      A_REV:    rd_data = {16'h0, REV_BYTE};
      A_TEST:   rd_data = test_q;
      A_STAT:   rd_data = {16'h0, {(8-NCH){1'b0}}, adc_rdy};
      A_CSUM:   rd_data = {8'h0, csum_q};
      A_ADC_ZS: rd_data = adc_zs_q;
      A_ADC_FS: rd_data = adc_fs_q;
      A_MODE:   rd_data = {16'h0, mode_q};
      default:  rd_data = '0;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == chan_addr(A_CH_ZS, c[0])) rd_data = zs_vec[c];
      if (rd_addr == chan_addr(A_CH_FS, c[0])) rd_data = fs_vec[c];
      if (rd_addr == chan_addr(A_RESULT, c[0]))
        rd_data = wide ? res_vec[c] : {8'h0, res_vec[c][DW-1:8]};
    end
  end

  // R6: the alias address records channel 1, the base address channel 0
  a_r6_mode_alt: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MODE_ALT) |=> (mode_ch && mode_q == $past(wr_data[7:0])));
  a_r6_mode_base: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MODE) |=> (!mode_ch && mode_q == $past(wr_data[7:0])));
  // R8: writes aimed at read-only or undefined locations leave storage alone
  a_r8_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_writable(wr_addr)) |=>
      ($stable(mode_q) && $stable(io_q) && $stable(adc_zs_q) && $stable(adc_fs_q)));
  // R13: the two reserved I/O bits stay clear
  a_r13_io_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    io_q[2:1] == 2'b00);
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter logic [3:0] REV_HI = 4'h2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           din,
  output logic           dout,
  input  logic [DW-1:0]  ch0_data,
  input  logic [DW-1:0]  ch1_data,
  input  logic [NCH-1:0] adc_rdy,
  output logic [7:0]     mode_q,
  output logic           mode_ch,
  output logic [7:0]     io_q,
  output logic [DW-1:0]  adc_zs_q,
  output logic [DW-1:0]  adc_fs_q
);
  logic          cs_s_n, sclk_s, din_s;
  logic [DW-1:0] rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          wr_en;

  sreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q({cs_s_n, sclk_s, din_s}));

  sreg_serial_if u_if (
    .clk(clk), .rst_n(rst_n), .cs_sync_n(cs_s_n), .sclk_sync(sclk_s),
    .din_sync(din_s), .mode_wide(mode_q[MODE_WIDE_BIT]), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout));

  sreg_bank #(.REV_HI(REV_HI)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ch0_data(ch0_data), .ch1_data(ch1_data), .adc_rdy(adc_rdy),
    .mode_q(mode_q), .mode_ch(mode_ch), .io_q(io_q),
    .adc_zs_q(adc_zs_q), .adc_fs_q(adc_fs_q));
endmodule

// File: tb/tb_sreg_port.sv
module tb_sreg_port;
  localparam int H = 8;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, mode_ch;
  logic [23:0] ch0_data = 24'h000000, ch1_data = 24'h000000;
  logic [1:0] adc_rdy = 2'b00;
  logic [7:0] mode_q, io_q;
  logic [23:0] adc_zs_q, adc_fs_q;

  int errs = 0, checks = 0, cycles = 0;
  bit done = 0, three_wire = 0;
  logic [23:0] m_reg [64];
  bit m_ch;

  sreg_port dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1; errs++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_writable(input int a);
    return a inside {1, 3, 5, 6, 7, 'h10, 'h12, 'h18, 'h1A, 'h38, 'h3A};
  endfunction

  function automatic int m_len(input int a);
    if (a inside {3, 6, 7, 'h10, 'h12, 'h18, 'h1A}) return 24;
    if (a == 5) return 16;
    if (a == 8 || a == 'hA) return m_reg['h38][1] ? 24 : 16;
    return 8;
  endfunction

  function automatic logic [23:0] m_read(input int a);
    logic [23:0] r;
    r = 24'h0;
    if (a == 2) r = 24'h24;
    else if (a == 4) r = {22'h0, adc_rdy};
    else if (a == 8 || a == 'hA) begin
      r = (a == 8) ? ch0_data : ch1_data;
      if (!m_reg['h38][1]) r = r >> 8;
    end else if (a != 'h3A && m_writable(a)) r = m_reg[a];
    return r;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 64; i++) m_reg[i] = 24'h0;
    m_reg[1] = 24'h30;
    m_reg[6] = 24'h800000; m_reg[7] = 24'h800000;
    m_reg['h10] = 24'h800000; m_reg['h12] = 24'h800000;
    m_reg['h18] = 24'h200000; m_reg['h1A] = 24'h200000;
    m_ch = 0;
  endtask

  task automatic m_write(input int a, input logic [23:0] v);
    int n;
    n = m_len(a);
    if (!m_writable(a)) return;
    if (a == 1) m_reg[1] = {16'h0, v[7:0] & 8'hF9};
    else if (a == 'h38 || a == 'h3A) begin
      m_reg['h38] = {16'h0, v[7:0]}; m_ch = (a == 'h3A);
    end else m_reg[a] = v & ((24'h1 << n) - 24'h1 | (n == 24 ? 24'hFFFFFF : 24'h0));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bits(input logic [23:0] v, input int n, output logic [23:0] got);
    got = 24'h0;
    for (int i = n - 1; i >= 0; i--) begin
      din = v[i];
      wait_clk(H);
      got[i] = dout;
      sclk = 1'b1;
      wait_clk(H);
      sclk = 1'b0;
    end
  endtask

  task automatic txn(input bit rd, input int a, input logic [23:0] wv,
                     output logic [23:0] rv, input string tag);
    logic [23:0] g;
    int n;
    if (!three_wire) begin cs_n = 1'b0; wait_clk(H); end
    put_bits({16'h0, 1'b0, rd, a[5:0]}, 8, g);
    chk({tag, " R3 cmd-quiet"}, g, 24'h0);
    n = m_len(a);
    put_bits(wv, n, rv);
    if (!rd) begin
      m_write(a, wv);
      chk({tag, " R3 write-quiet"}, rv, 24'h0);
    end
    if (!three_wire) begin wait_clk(H); cs_n = 1'b1; end
    wait_clk(2 * H);
  endtask

  task automatic rd_chk(input int a, input string tag);
    logic [23:0] rv, ex;
    ex = m_read(a);
    txn(1'b1, a, 24'h0, rv, tag);
    chk(tag, rv, ex);
  endtask

  task automatic wr(input int a, input logic [23:0] v, input string tag);
    logic [23:0] rv;
    txn(1'b0, a, v, rv, tag);
  endtask

  task automatic port_chk(input string tag);
    chk({tag, " mode_q"}, {16'h0, mode_q}, m_reg['h38]);
    chk({tag, " mode_ch"}, {23'h0, mode_ch}, {23'h0, m_ch});
    chk({tag, " io_q"}, {16'h0, io_q}, m_reg[1]);
    chk({tag, " adc_zs"}, adc_zs_q, m_reg[6]);
    chk({tag, " adc_fs"}, adc_fs_q, m_reg[7]);
  endtask

  initial begin
    logic [23:0] g;
    m_reset();
    wait_clk(4); rst_n = 1'b1; wait_clk(4);

    // R4 power-on state
    port_chk("R4 reset");
    rd_chk(2, "R4 revision");
    rd_chk('h18, "R4 ch0 full-scale");
    rd_chk('h1A, "R4 ch1 full-scale");
    rd_chk('h10, "R4 ch0 zero-scale");
    rd_chk(3, "R4 test");

    // R1 / R2 lengths and writes
    wr(6, 24'h123456, "R1 write adc zs");
    rd_chk(6, "R1 R2 read adc zs 24b");
    wr(5, 24'h00BEEF, "R2 write checksum");
    rd_chk(5, "R2 checksum 16b");
    wr('h12, 24'hA5C3F0, "R2 write ch1 zs");
    rd_chk('h12, "R2 ch1 zs");
    rd_chk('h10, "R2 ch0 zs untouched");

    // R13 I/O port
    wr(1, 24'h0000FF, "R13 io write");
    rd_chk(1, "R13 io readback");
    port_chk("R13 ports");

    // R5 result width
    ch0_data = 24'hABCDEF; ch1_data = 24'h80017E;
    rd_chk(8, "R5 ch0 16b");
    rd_chk('hA, "R5 ch1 16b");
    wr('h38, 24'h000002, "R5 set wide");
    rd_chk(8, "R5 ch0 24b");
    rd_chk('hA, "R5 ch1 24b");

    // R6 mode aliases
    wr('h3A, 24'h000003, "R6 write via alias");
    port_chk("R6 alias ports");
    rd_chk('h3A, "R6 alias read zero");
    rd_chk('h38, "R6 base read");
    wr('h38, 24'h000000, "R6 write via base");
    port_chk("R6 base ports");

    // R7 zero reads
    rd_chk(0, "R7 comm reg");
    rd_chk('h2F, "R7 undefined");

    // R8 read-only writes
    wr(2, 24'h0000FF, "R8 write revision");
    rd_chk(2, "R8 revision kept");
    wr(8, 24'h00FFFF, "R8 write result");
    wr(4, 24'h0000FF, "R8 write status");
    rd_chk(6, "R8 framing after ro write");
    port_chk("R8 ports");

    // R12 status
    adc_rdy = 2'b10;
    rd_chk(4, "R12 status 10");
    adc_rdy = 2'b01;
    rd_chk(4, "R12 status 01");

    // R9 abort mid-data
    cs_n = 1'b0; wait_clk(H);
    put_bits({16'h0, 8'h07}, 8, g);
    put_bits(24'h3FF, 10, g);
    wait_clk(H); cs_n = 1'b1; wait_clk(3 * H);
    port_chk("R9 abort");
    rd_chk(7, "R9 adc fs unchanged");
    rd_chk(2, "R9 framing restored");

    // R10 3-wire back to back
    three_wire = 1; cs_n = 1'b0; wait_clk(4 * H);
    wr('h1A, 24'hABCDE1, "R10 write");
    rd_chk('h1A, "R10 read ch1 fs");
    wr('h38, 24'h000002, "R10 wide");
    rd_chk('hA, "R10 wide result");
    rd_chk(2, "R10 revision");
    wr('h38, 24'h000000, "R10 narrow");
    rd_chk(8, "R10 narrow result");
    three_wire = 0; cs_n = 1'b1; wait_clk(2 * H);

    // R11 reset mid-transaction
    wr('h38, 24'h0000C2, "R11 prep mode");
    cs_n = 1'b0; wait_clk(H);
    put_bits({16'h0, 8'h06}, 8, g);
    put_bits(24'h5, 3, g);
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0;
    wait_clk(4); rst_n = 1'b1; wait_clk(4);
    m_reset();
    port_chk("R11 after reset");
    rd_chk(6, "R11 adc zs");
    rd_chk('h1A, "R11 ch1 fs");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule